// File: doc/BRIEF.md
# Video Memory Cycle Decoder

This block is a cycle-level, synthesizable model of the random-access side of a dual-function video memory. The row strobe, column strobe, write enable, output enable and special-function select all arrive as active-low (or, for the special-function select, active-high) levels that are sampled on the system clock. At the clock edge that first samples the row strobe low, the block captures the row address from the shared address bus. It also picks a cycle type from the other strobe levels. That type holds until the row strobe returns high.

Three cycle types do work. A page cycle gives access to any column of the captured row: each new column strobe falling edge captures a column, and reads and writes may follow one another freely. A color-register cycle reads or writes the four-bit color register through the same column-strobe protocol. A flash cycle uses the data bus as a per-bit mask and, at the row-strobe edge, loads every word of the addressed row with the color register on the masked bits. A watchdog flags a row strobe that has been held low for too long.

The strobes are plain synchronous inputs. A column-strobe falling edge must come at least one clock after the row-strobe falling edge. The data bus is split into an input, an output and an output-enable, so the tri-state buffer sits outside the block.

Top module: `vram_cycle_core`

## Requirements
- R1: At the clock edge that first samples `ras_n` low, the cycle type is decoded from the levels sampled at that edge. With `cas_n` and `oe_n` high and `dsf` low, a page cycle is chosen, whatever the level of `we_n`. A page cycle never alters a row that it does not write.
- R2: If `cas_n`, `oe_n`, `we_n` and `dsf` are all high, a color-register cycle is chosen. In that cycle a column write (early or delayed) loads `dq_i` into the 4-bit color register, and a column read returns it. The register keeps its value until the next such write.
- R3: If `cas_n` and `oe_n` are high, `we_n` is low and `dsf` is high, a flash cycle is chosen. At that same edge, row `addr[ROW_W-1:0]` is updated in all COLS words. Bit i of each word takes color-register bit i where `dq_i[i]` is 1, and keeps its old value where `dq_i[i]` is 0.
- R4: A read access is a column-strobe falling edge in a page or color-register cycle. It captures `addr` as the column, and from the next clock `dq_o` holds the selected word. `dq_oe` is 1 exactly on the clocks following an edge that sampled `ras_n` low, `cas_n` low, `oe_n` low and `we_n` high in a page or color-register cycle. `dq_o` stays steady while `cas_n` stays low.
- R5: In a page cycle, an early write (`we_n` low at the column-strobe falling edge) writes `dq_i` to the column on that edge. A delayed write (`we_n` falling while `cas_n` is held low) writes `dq_i` to the column captured at the last column-strobe falling edge.
- R6: Within one row-strobe low period, any number of column accesses to different columns may mix reads and writes, and each read returns the latest write to its column.
- R7: Any other strobe combination at the row-strobe edge (for example `oe_n` or `cas_n` low) gives an idle cycle. An idle cycle writes no word and no color register, and never asserts `dq_oe`.
- R8: `ras_overrun` becomes 1 once `ras_n` has been sampled low on more than RAS_MAX_CLKS consecutive clock edges. It returns to 0 on the first edge that samples `ras_n` high.
- R9: A synchronous reset (`rst` high) clears the color register, `dq_o`, `dq_oe` and `ras_overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| dsf | input | 1 | Special-function select |
| addr | input | ADDR_W | Multiplexed row / column address |
| dq_i | input | DQ_W | Write data, or mask in a flash cycle |
| dq_o | output | DQ_W | Registered read data |
| dq_oe | output | 1 | Drive enable for the external data buffer |
| ras_overrun | output | 1 | Row strobe held low too long |

## Verification
A wrongly decoded cycle type shows up at the first column access after the row strobe. The symptoms are a read that does not drive the bus, a read that returns the color register instead of the array, or a write that reaches the wrong store. A faulty flash mask or a faulty column capture stays hidden until that row and column are read back, so the bench follows every flash by reads at both column ends and compares every read with a model it updates itself. A fault in the overrun counter shows in the exact clock at which the flag rises.

// File: rtl/vram_pkg.sv
package vram_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_PAGE  = 2'd1,
    CYC_CREG  = 2'd2,
    CYC_FLASH = 2'd3
  } cyc_e;

  // Cycle selection from strobe levels at the row-strobe falling edge.
  function automatic cyc_e pick_cycle(input logic cas_lvl, input logic oe_lvl,
                                      input logic we_lvl, input logic dsf_lvl);
    if (!cas_lvl || !oe_lvl) return CYC_IDLE;
    if (!dsf_lvl)            return CYC_PAGE;
    if (we_lvl)              return CYC_CREG;
    return CYC_FLASH;
  endfunction

endpackage

// File: rtl/vram_strobe_ctl.sv
module vram_strobe_ctl
  import vram_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int ROW_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              dsf,
  input  logic [ADDR_W-1:0] addr,
  output cyc_e              mode,
  output logic [ROW_W-1:0]  row,
  output logic [ADDR_W-1:0] col,
  output logic              cas_fall,
  output logic              wr_evt,
  output logic              fill_go
);

  logic ras_q, cas_q, we_q;
  logic ras_fall;
  cyc_e mode_q;
  logic [ROW_W-1:0]  row_q;
  logic [ADDR_W-1:0] col_q;

  assign ras_fall = ras_q & ~ras_n;
  assign cas_fall = cas_q & ~cas_n;
  // early write at the column edge, or delayed write while the column strobe is held
  assign wr_evt   = (cas_fall & ~we_n) | (~cas_q & ~cas_n & we_q & ~we_n);
  assign fill_go  = ras_fall && (pick_cycle(cas_n, oe_n, we_n, dsf) == CYC_FLASH);
  assign col      = cas_fall ? addr : col_q;
  assign mode     = mode_q;
  assign row      = row_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_q  <= 1'b1;
      cas_q  <= 1'b1;
      we_q   <= 1'b1;
      mode_q <= CYC_IDLE;
      row_q  <= '0;
      col_q  <= '0;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      we_q  <= we_n;
      if (ras_n) begin
        mode_q <= CYC_IDLE;
      end else if (ras_fall) begin
        mode_q <= pick_cycle(cas_n, oe_n, we_n, dsf);
        row_q  <= addr[ROW_W-1:0];
      end
      if (cas_fall) col_q <= addr;
    end
  end

endmodule

// File: rtl/vram_row_array.sv
module vram_row_array #(
  parameter int ROWS  = 8,
  parameter int COLS  = 512,
  parameter int DQ_W  = 4,
  parameter int ROW_W = 3,
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [COL_W-1:0] wr_col,
  input  logic [DQ_W-1:0]  wr_data,
  input  logic             fill_en,
  input  logic [ROW_W-1:0] fill_row,
  input  logic [DQ_W-1:0]  fill_mask,
  input  logic [DQ_W-1:0]  fill_color,
  input  logic [ROW_W-1:0] rd_row,
  input  logic [COL_W-1:0] rd_col,
  output logic [DQ_W-1:0]  rd_data
);

  localparam int ROW_BITS = COLS * DQ_W;

  logic [ROW_BITS-1:0] mem [ROWS];
  logic [ROW_BITS-1:0] mask_row, color_row;

  // spread the per-bit mask and colour across every word of a row
  for (genvar c = 0; c < COLS; c++) begin : g_spread
    assign mask_row[c*DQ_W +: DQ_W]  = fill_mask;
    assign color_row[c*DQ_W +: DQ_W] = fill_color;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      mem[fill_row] <= (mem[fill_row] & ~mask_row) | (color_row & mask_row);
    end else if (wr_en) begin
      mem[wr_row][wr_col*DQ_W +: DQ_W] <= wr_data;
    end
  end

  assign rd_data = mem[rd_row][rd_col*DQ_W +: DQ_W];

endmodule

// File: rtl/vram_ras_watch.sv
module vram_ras_watch #(
  parameter int MAX_LOW = 12500
) (
  input  logic clk,
  input  logic rst,
  input  logic ras_n,
  output logic overrun
);

  localparam int CW = $clog2(MAX_LOW + 2);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || ras_n) begin
      low_cnt <= '0;
      overrun <= 1'b0;
    end else begin
      if (low_cnt <= CW'(MAX_LOW)) low_cnt <= low_cnt + 1'b1;
      overrun <= (low_cnt >= CW'(MAX_LOW));
    end
  end

endmodule

// File: rtl/vram_cycle_core.sv
module vram_cycle_core
  import vram_pkg::*;
#(
  parameter int ROWS         = 8,
  parameter int COLS         = 512,
  parameter int DQ_W         = 4,
  parameter int ADDR_W       = $clog2(COLS),
  parameter int RAS_MAX_CLKS = 12500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              dsf,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq_i,
  output logic [DQ_W-1:0]   dq_o,
  output logic              dq_oe,
  output logic              ras_overrun
);

  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;

  cyc_e              mode;
  logic [ROW_W-1:0]  row;
  logic [ADDR_W-1:0] col;
  logic              cas_fall, wr_evt, fill_go;
  logic [DQ_W-1:0]   creg_q, rd_word;
  logic              wr_go, page_wr, creg_wr, rd_mode;

  vram_strobe_ctl #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_ctl (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .dsf(dsf), .addr(addr), .mode(mode), .row(row),
    .col(col), .cas_fall(cas_fall), .wr_evt(wr_evt), .fill_go(fill_go)
  );

  assign wr_go   = wr_evt & ~ras_n;
  assign page_wr = wr_go && (mode == CYC_PAGE);
  assign creg_wr = wr_go && (mode == CYC_CREG);
  assign rd_mode = (mode == CYC_PAGE) || (mode == CYC_CREG);

  vram_row_array #(
    .ROWS(ROWS), .COLS(COLS), .DQ_W(DQ_W), .ROW_W(ROW_W), .COL_W(ADDR_W)
  ) u_arr (
    .clk(clk),
    .wr_en(page_wr), .wr_row(row), .wr_col(col), .wr_data(dq_i),
    .fill_en(fill_go), .fill_row(addr[ROW_W-1:0]), .fill_mask(dq_i),
    .fill_color(creg_q),
    .rd_row(row), .rd_col(col), .rd_data(rd_word)
  );

  vram_ras_watch #(.MAX_LOW(RAS_MAX_CLKS)) u_watch (
    .clk(clk), .rst(rst), .ras_n(ras_n), .overrun(ras_overrun)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      creg_q <= '0;
      dq_o   <= '0;
      dq_oe  <= 1'b0;
    end else begin
      if (creg_wr) creg_q <= dq_i;
      if (cas_fall && !ras_n && rd_mode) begin
        dq_o <= (mode == CYC_CREG) ? creg_q : rd_word;
      end
      dq_oe <= !ras_n && !cas_n && !oe_n && we_n && rd_mode;
    end
  end

endmodule

// File: rtl/vram_cycle_chk.sv
module vram_cycle_chk #(
  parameter int DQ_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            ras_n,
  input logic            cas_n,
  input logic            we_n,
  input logic            oe_n,
  input logic [DQ_W-1:0] dq_o,
  input logic            dq_oe,
  input logic            ras_overrun
);

  AST_OE_NEEDS_STROBES: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> $past(!ras_n && !cas_n && !oe_n && we_n)); // R4

  AST_DQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (!cas_n && $past(!cas_n) && $past(!cas_n, 2) && !$past(rst) && !$past(rst, 2))
      |-> $stable(dq_o)); // R4

  AST_OVERRUN_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ras_n |=> !ras_overrun); // R8

  AST_OVERRUN_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
    ras_overrun |-> $past(!ras_n)); // R8

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dq_oe && !ras_overrun)); // R9

endmodule

bind vram_cycle_core vram_cycle_chk #(.DQ_W(DQ_W)) u_chk (
  .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .oe_n(oe_n), .dq_o(dq_o), .dq_oe(dq_oe), .ras_overrun(ras_overrun)
);

// File: tb/tb_vram_cycle_core.sv
`timescale 1ns/1ps
module tb_vram_cycle_core;

  localparam int ROWS = 8;
  localparam int COLS = 512;
  localparam int DQ_W = 4;
  localparam int AW   = 9;
  localparam int RMAX = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, dsf = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [DQ_W-1:0] dq_i = '0;
  logic [DQ_W-1:0] dq_o;
  logic            dq_oe, ras_overrun;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [DQ_W-1:0] mdl [ROWS][COLS];
  logic [DQ_W-1:0] mcreg = '0;
  int cur_row  = 0;
  int cur_mode = 0; // 0 idle, 1 page, 2 color register, 3 flash

  always #4 clk = ~clk;

  vram_cycle_core #(.ROWS(ROWS), .COLS(COLS), .DQ_W(DQ_W), .RAS_MAX_CLKS(RMAX)) dut (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .dsf(dsf), .addr(addr), .dq_i(dq_i), .dq_o(dq_o),
    .dq_oe(dq_oe), .ras_overrun(ras_overrun)
  );

  function automatic int exp_mode(logic c, logic o, logic w, logic d);
    if (!c || !o) return 0;
    if (!d) return 1;
    return w ? 2 : 3;
  endfunction

  function automatic logic [DQ_W-1:0] flash_word(logic [DQ_W-1:0] old,
      logic [DQ_W-1:0] msk, logic [DQ_W-1:0] colr);
    return (old & ~msk) | (colr & msk);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ras_open(input int row, input logic c, input logic o,
                          input logic w, input logic d, input logic [DQ_W-1:0] dv);
    cas_n = c; oe_n = o; we_n = w; dsf = d; addr = AW'(row); dq_i = dv; ras_n = 1'b0;
    cur_row  = row;
    cur_mode = exp_mode(c, o, w, d);
    if (cur_mode == 3)
      for (int k = 0; k < COLS; k++) mdl[row][k] = flash_word(mdl[row][k], dv, mcreg);
    tick();
    cas_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; dsf = 1'b0;
  endtask

  task automatic ras_close();
    ras_n = 1'b1; cas_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; dsf = 1'b0;
    tick();
    cur_mode = 0;
  endtask

  task automatic col_read(input int col, input string req);
    logic [DQ_W-1:0] e;
    addr = AW'(col); we_n = 1'b1; oe_n = 1'b0; cas_n = 1'b0;
    tick();
    if (cur_mode == 1 || cur_mode == 2) begin
      e = (cur_mode == 2) ? mcreg : mdl[cur_row][col];
      check(dq_oe === 1'b1, req, "read drive", int'(dq_oe), 1);
      check(dq_o === e, req, "read data", int'(dq_o), int'(e));
    end else begin
      check(dq_oe === 1'b0, req, "idle no drive", int'(dq_oe), 0);
    end
    cas_n = 1'b1; oe_n = 1'b1;
    tick();
  endtask

  task automatic apply_write(input int col, input logic [DQ_W-1:0] d);
    if (cur_mode == 1) mdl[cur_row][col] = d;
    else if (cur_mode == 2) mcreg = d;
  endtask

  task automatic col_write_early(input int col, input logic [DQ_W-1:0] d, input string req);
    addr = AW'(col); dq_i = d; we_n = 1'b0; oe_n = 1'b0; cas_n = 1'b0;
    tick();
    apply_write(col, d);
    check(dq_oe === 1'b0, req, "no drive on write", int'(dq_oe), 0);
    cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    tick();
  endtask

  task automatic col_write_late(input int col, input logic [DQ_W-1:0] d);
    addr = AW'(col); we_n = 1'b1; oe_n = 1'b1; cas_n = 1'b0;
    tick();
    addr = AW'($urandom % COLS); dq_i = d; we_n = 1'b0;
    tick();
    apply_write(col, d);
    we_n = 1'b1; cas_n = 1'b1;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R9: reset state
    check(dq_oe === 1'b0, "R9", "dq_oe after reset", int'(dq_oe), 0);
    check(ras_overrun === 1'b0, "R9", "overrun after reset", int'(ras_overrun), 0);
    ras_open(0, 1, 1, 1, 1, '0);
    col_read(5, "R9"); // colour register clears to 0
    ras_close();

    // R3: clear every row with full mask and zero colour
    for (int r = 0; r < ROWS; r++) begin
      ras_open(r, 1, 1, 0, 1, 4'hF);
      ras_close();
    end

    // R2: early and delayed color register writes, read back
    ras_open(2, 1, 1, 1, 1, '0);
    col_write_early(0, 4'hA, "R2");
    ras_close();
    ras_open(1, 1, 1, 1, 1, '0);
    col_read(0, "R2");
    col_write_late(7, 4'h5);
    col_read(3, "R2");
    ras_close();

    // R3: flash with partial masks, check both row ends
    ras_open(3, 1, 1, 0, 1, 4'b0110);
    ras_close();
    ras_open(3, 1, 1, 1, 0, '0);
    col_read(0, "R3"); col_read(1, "R3"); col_read(COLS-1, "R3");
    col_write_early(100, 4'h8, "R5");
    ras_close();
    ras_open(2, 1, 1, 1, 1, '0);
    col_write_early(0, 4'h3, "R2");
    ras_close();
    ras_open(3, 1, 1, 0, 1, 4'b1001);
    ras_close();
    ras_open(3, 1, 1, 1, 0, '0);
    col_read(100, "R3"); col_read(COLS-1, "R3");
    ras_close();

    // R5, R6: early and delayed writes mixed with reads in one row cycle
    ras_open(4, 1, 1, 1, 0, '0);
    col_write_early(10, 4'hC, "R5");
    col_write_late(11, 4'h7);
    col_read(10, "R6"); col_read(11, "R5");
    col_write_early(10, 4'h1, "R6");
    col_read(10, "R6");
    ras_close();

    // R4: output enable gating
    ras_open(4, 1, 1, 1, 0, '0);
    addr = AW'(11); cas_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
    tick();
    check(dq_oe === 1'b0, "R4", "oe high no drive", int'(dq_oe), 0);
    oe_n = 1'b0;
    tick();
    check(dq_oe === 1'b1, "R4", "oe low drives", int'(dq_oe), 1);
    check(dq_o === mdl[4][11], "R4", "captured column", int'(dq_o), int'(mdl[4][11]));
    addr = AW'(10);
    tick();
    check(dq_o === mdl[4][11], "R4", "held while cas low", int'(dq_o), int'(mdl[4][11]));
    cas_n = 1'b1; oe_n = 1'b1;
    tick();
    check(dq_oe === 1'b0, "R4", "release on cas high", int'(dq_oe), 0);
    ras_close();

    // R7: idle cycle (oe low at row edge) ignores writes and never drives
    ras_open(4, 1, 0, 1, 0, '0);
    col_write_early(10, 4'hE, "R7");
    col_read(10, "R7");
    ras_close();
    ras_open(0, 1, 1, 1, 1, '0);
    col_read(0, "R7"); // colour register untouched
    ras_close();
    ras_open(4, 1, 1, 1, 0, '0);
    col_read(10, "R7");
    ras_close();

    // R1: we low with dsf low is still a page cycle, no flash
    ras_open(4, 1, 1, 0, 0, 4'hF);
    col_read(10, "R1"); col_read(11, "R1");
    ras_close();

    // mixed random traffic
    for (int it = 0; it < 160; it++) begin
      int kind;
      kind = int'($urandom % 4);
      if (kind == 0) begin
        ras_open(int'($urandom % ROWS), 1, 1, 1'($urandom), 0, '0);
        for (int j = 0; j < 1 + int'($urandom % 5); j++) begin
          int col;
          col = ($urandom % 4 == 0) ? COLS-1 : int'($urandom % COLS);
          case ($urandom % 3)
            0: col_write_early(col, DQ_W'($urandom), "R5");
            1: col_write_late(col, DQ_W'($urandom));
            default: col_read(col, "R6");
          endcase
        end
        ras_close();
      end else if (kind == 1) begin
        ras_open(int'($urandom % ROWS), 1, 1, 1, 1, '0);
        col_write_early(int'($urandom % COLS), DQ_W'($urandom), "R2");
        ras_close();
      end else if (kind == 2) begin
        int r;
        r = int'($urandom % ROWS);
        ras_open(r, 1, 1, 0, 1, DQ_W'($urandom));
        ras_close();
        ras_open(r, 1, 1, 1, 0, '0);
        col_read(0, "R3"); col_read(COLS-1, "R3");
        ras_close();
      end else begin
        ras_open(int'($urandom % ROWS), 1, 1, 1, 1, '0);
        col_read(int'($urandom % COLS), "R2");
        ras_close();
      end
    end

    // R8: row strobe held low
    ras_open(5, 1, 1, 1, 0, '0);
    repeat (RMAX - 1) tick();
    check(ras_overrun === 1'b0, "R8", "at limit", int'(ras_overrun), 0);
    tick();
    check(ras_overrun === 1'b1, "R8", "past limit", int'(ras_overrun), 1);
    ras_close();
    check(ras_overrun === 1'b0, "R8", "cleared", int'(ras_overrun), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule